// File: doc/BRIEF.md
# Ternary Flow Steering Match Table

This block classifies received frames for flow steering. Software loads up to `NUM_ENTRIES` ternary entries. Each entry holds a value and a mask over a 424-bit header tuple, which covers both MAC addresses, both IP addresses, the EtherType, both L4 ports, the VLAN tag and the IP protocol. Each entry also holds an enable flag and a 16-bit steering result. Software also splits the table into contiguous, cumulative windows, one for each station interface. The first interface owns the lowest entries, and each later interface's window starts right after the previous one ends.

A lookup gives a parsed tuple and the number of the receiving interface. Only enabled entries inside that interface's window are compared. When several of them match, the lowest-indexed one wins. One cycle later the block returns a match flag, the winning index and its result. A global enable acts as a two-state controller. In TBL_OFF the block answers every lookup with "no match". A mode write with bit 31 set moves it to TBL_ON, and a mode write with bit 31 clear returns it to TBL_OFF. Reset enters TBL_OFF. A window setting whose total exceeds the capacity is refused.

Top module: `tfs_match_table`

## Requirements
- R1: An entry matches a key when every key bit whose mask bit is 1 equals the entry's value bit; key bits under a 0 mask bit are ignored. The key layout, from bit 0 upward, is: protocol [7:0], VLAN [23:8], destination port [39:24], source port [55:40], EtherType [71:56], destination IP [199:72], source IP [327:200], destination MAC [375:328], source MAC [423:376].
- R2: An entry takes part only while bit 15 of its written flags word is 1; the other flag bits have no effect.
- R3: Among several matching entries, the one with the numerically lowest index is reported.
- R4: Window sizes are written together, interface n in `cfg_win_data[n*7 +: 7]`. The window of interface n starts at the sum of the sizes of interfaces 0..n-1. Only entries inside the lookup interface's window can match, and a zero-size window never matches.
- R5: A window write whose sizes sum to more than `NUM_ENTRIES` is rejected. The previous windows are kept and `cfg_err` goes to 1. An accepted write, including one that sums to exactly `NUM_ENTRIES`, clears `cfg_err`.
- R6: `cap_code` reports the capacity as a 4-bit code c, with capacity = (c+1)*16. With 64 entries, c is 3.
- R7: Bit 31 of a mode write selects TBL_ON (1) or TBL_OFF (0), and the other mode bits are ignored. In TBL_OFF every lookup reports no match.
- R8: `res_valid` is 1 in exactly the cycle after a cycle with `lk_valid` set, and 0 otherwise.
- R9: A lookup with no qualifying match reports `res_match`=0, `res_index`=0 and `res_result`=0.
- R10: After reset the block is in TBL_OFF, all entries are disabled, all windows are empty, `cfg_err` is 0 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_entry_we | input | 1 | Write one table entry |
| cfg_entry_idx | input | 6 | Entry index to write |
| cfg_entry_val | input | 424 | Entry value tuple |
| cfg_entry_msk | input | 424 | Entry mask, 1 = bit compared |
| cfg_entry_flags | input | 16 | Flags word, bit 15 = entry enable |
| cfg_entry_result | input | 16 | Steering result of the entry |
| cfg_mode_we | input | 1 | Write the mode word |
| cfg_mode_data | input | 32 | Mode word, bit 31 = table enable |
| cfg_win_we | input | 1 | Write all window sizes |
| cfg_win_data | input | 28 | Packed 7-bit window sizes per interface |
| cfg_err | output | 1 | Last window write was rejected |
| cap_code | output | 4 | Capacity code |
| lk_valid | input | 1 | Lookup request |
| lk_si | input | 2 | Receiving interface of the lookup |
| lk_key | input | 424 | Header tuple to classify |
| res_valid | output | 1 | Lookup answer valid |
| res_match | output | 1 | An entry matched |
| res_index | output | 6 | Winning entry index |
| res_result | output | 16 | Winning entry result |

## Verification
The bench sets up overlapping entries so that one key hits several of them at once. A picker that favoured the highest index or the last-written entry would then report the wrong index. It probes the first and last entry of a window and an empty window, and it places an entry just past the windows: an off-by-one window bound would either lose a match at the edge or steer into a neighbour's entries. Window writes are tried at exactly capacity and one above it. A design that checked with the wrong comparison, or that took the rejected sizes, would flag the legal write or move the windows. Disabled entries, a mode word with every bit except 31 set, and a fresh reset each must give "no match", which catches an enable decoded from the wrong bit.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    localparam int MAC_W    = 48;
    localparam int IP_W     = 128;
    localparam int ETYPE_W  = 16;
    localparam int PORT_W   = 16;
    localparam int VLAN_W   = 16;
    localparam int PROTO_W  = 8;
    // key: {smac, dmac, sip, dip, etype, sport, dport, vlan, proto}, proto at bit 0
    localparam int KEY_W    = 2*MAC_W + 2*IP_W + ETYPE_W + 2*PORT_W + VLAN_W + PROTO_W;
    localparam int RES_W    = 16;
    localparam int FLAGS_W  = 16;
    localparam int FLAG_EN_BIT = 15;
    localparam int MODE_W   = 32;
    localparam int MODE_EN_BIT = 31;
    localparam int CAP_W    = 4;

    typedef enum logic {
        TBL_OFF = 1'b0,
        TBL_ON  = 1'b1
    } tbl_state_e;
endpackage

// File: rtl/tfs_entry_store.sv
module tfs_entry_store
    import tfs_pkg::*;
#(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [KEY_W-1:0]   wr_val,
    input  logic [KEY_W-1:0]   wr_msk,
    input  logic               wr_on,
    input  logic [RES_W-1:0]   wr_res,
    input  logic [KEY_W-1:0]   key,
    output logic [N-1:0]       hit,
    output logic [N*RES_W-1:0] res_flat
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_ent
            logic [KEY_W-1:0] val_q;
            logic [KEY_W-1:0] msk_q;
            logic             on_q;
            logic [RES_W-1:0] res_q;
            logic             sel;

            assign sel = wr_en && (wr_idx == IDX_W'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                    msk_q <= '0;
                    on_q  <= 1'b0;
                    res_q <= '0;
                end else if (sel) begin
                    val_q <= wr_val & wr_msk;
                    msk_q <= wr_msk;
                    on_q  <= wr_on;
                    res_q <= wr_res;
                end
            end

            assign hit[g] = on_q && ((key & msk_q) == val_q);
            assign res_flat[g*RES_W +: RES_W] = res_q;
        end
    endgenerate
endmodule

// File: rtl/tfs_window_cfg.sv
module tfs_window_cfg #(
    parameter int NUM_SI = 4,
    parameter int N      = 64,
    parameter int WIN_W  = $clog2(N + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [NUM_SI*WIN_W-1:0] wr_sizes,
    output logic [NUM_SI*WIN_W-1:0] lo_flat,
    output logic [NUM_SI*WIN_W-1:0] hi_flat,
    output logic                    reject,
    output logic                    err
);
    localparam int SUM_W = WIN_W + $clog2(NUM_SI) + 1;

    logic [WIN_W-1:0] size_q [NUM_SI];
    logic [SUM_W-1:0] req_total;
    logic             err_q;

    always_comb begin
        req_total = '0;
        for (int n = 0; n < NUM_SI; n++) begin
            req_total = req_total + SUM_W'(wr_sizes[n*WIN_W +: WIN_W]);
        end
    end

    assign reject = wr_en && (req_total > SUM_W'(N));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_SI; n++) size_q[n] <= '0;
            err_q <= 1'b0;
        end else if (wr_en) begin
            if (reject) begin
                err_q <= 1'b1;
            end else begin
                err_q <= 1'b0;
                for (int n = 0; n < NUM_SI; n++) size_q[n] <= wr_sizes[n*WIN_W +: WIN_W];
            end
        end
    end

    // cumulative windows: stored total never exceeds N, so WIN_W bits suffice
    always_comb begin
        logic [WIN_W-1:0] run;
        run = '0;
        for (int n = 0; n < NUM_SI; n++) begin
            lo_flat[n*WIN_W +: WIN_W] = run;
            run = run + size_q[n];
            hi_flat[n*WIN_W +: WIN_W] = run;
        end
    end

    assign err = err_q;
endmodule

// File: rtl/tfs_prio_pick.sv
module tfs_prio_pick #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tfs_match_table.sv
module tfs_match_table
    import tfs_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int NUM_SI      = 4,
    parameter int IDX_W       = $clog2(NUM_ENTRIES),
    parameter int SI_W        = $clog2(NUM_SI),
    parameter int WIN_W       = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_entry_we,
    input  logic [IDX_W-1:0]         cfg_entry_idx,
    input  logic [KEY_W-1:0]         cfg_entry_val,
    input  logic [KEY_W-1:0]         cfg_entry_msk,
    input  logic [FLAGS_W-1:0]       cfg_entry_flags,
    input  logic [RES_W-1:0]         cfg_entry_result,
    input  logic                     cfg_mode_we,
    input  logic [MODE_W-1:0]        cfg_mode_data,
    input  logic                     cfg_win_we,
    input  logic [NUM_SI*WIN_W-1:0]  cfg_win_data,
    output logic                     cfg_err,
    output logic [CAP_W-1:0]         cap_code,
    input  logic                     lk_valid,
    input  logic [SI_W-1:0]          lk_si,
    input  logic [KEY_W-1:0]         lk_key,
    output logic                     res_valid,
    output logic                     res_match,
    output logic [IDX_W-1:0]         res_index,
    output logic [RES_W-1:0]         res_result
);
    localparam int CAP_CODE = NUM_ENTRIES / 16 - 1;

    tbl_state_e state_q, state_d;

    logic [NUM_ENTRIES-1:0]       hit_raw;
    logic [NUM_ENTRIES-1:0]       in_win;
    logic [NUM_ENTRIES*RES_W-1:0] res_flat;
    logic [NUM_SI*WIN_W-1:0]      lo_flat, hi_flat;
    logic [WIN_W-1:0]             sel_lo, sel_hi;
    logic                         win_reject;
    logic                         pick_found;
    logic [IDX_W-1:0]             pick_idx;
    logic [RES_W-1:0]             pick_res;
    logic                         flags_unused, mode_unused;

    assign flags_unused = ^cfg_entry_flags[FLAG_EN_BIT-1:0];
    assign mode_unused  = ^cfg_mode_data[MODE_EN_BIT-1:0];
    assign cap_code     = CAP_W'(CAP_CODE);

    tfs_entry_store #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_entry_we),
        .wr_idx   (cfg_entry_idx),
        .wr_val   (cfg_entry_val),
        .wr_msk   (cfg_entry_msk),
        .wr_on    (cfg_entry_flags[FLAG_EN_BIT]),
        .wr_res   (cfg_entry_result),
        .key      (lk_key),
        .hit      (hit_raw),
        .res_flat (res_flat)
    );

    tfs_window_cfg #(.NUM_SI(NUM_SI), .N(NUM_ENTRIES), .WIN_W(WIN_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_win_we),
        .wr_sizes (cfg_win_data),
        .lo_flat  (lo_flat),
        .hi_flat  (hi_flat),
        .reject   (win_reject),
        .err      (cfg_err)
    );

    always_comb begin
        if (int'(lk_si) < NUM_SI) begin
            sel_lo = lo_flat[int'(lk_si)*WIN_W +: WIN_W];
            sel_hi = hi_flat[int'(lk_si)*WIN_W +: WIN_W];
        end else begin
            sel_lo = '0;
            sel_hi = '0;
        end
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            in_win[i] = (WIN_W'(i) >= sel_lo) && (WIN_W'(i) < sel_hi);
        end
    end

    tfs_prio_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
        .req   (hit_raw & in_win),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign pick_res = res_flat[int'(pick_idx)*RES_W +: RES_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TBL_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TBL_OFF: if (cfg_mode_we &&  cfg_mode_data[MODE_EN_BIT]) state_d = TBL_ON;
            TBL_ON:  if (cfg_mode_we && !cfg_mode_data[MODE_EN_BIT]) state_d = TBL_OFF;
            default: state_d = TBL_OFF;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_match  <= 1'b0;
            res_index  <= '0;
            res_result <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                if (state_q == TBL_ON && pick_found) begin
                    res_match  <= 1'b1;
                    res_index  <= pick_idx;
                    res_result <= pick_res;
                end else begin
                    res_match  <= 1'b0;
                    res_index  <= '0;
                    res_result <= '0;
                end
            end
        end
    end

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_match) |-> (res_result == '0 && res_index == '0));
    assert_off_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && state_q == TBL_OFF) |=> !res_match);
    assert_reject_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_reject |=> cfg_err);
    assert_reject_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_reject |=> ($stable(lo_flat) && $stable(hi_flat)));
    assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && pick_found) |=>
            (!res_match || (WIN_W'(res_index) >= $past(sel_lo) && WIN_W'(res_index) < $past(sel_hi))));
endmodule

// File: tb/tfs_match_table_tb_top.sv
`timescale 1ns/1ps
module tfs_match_table_tb_top;
    localparam int KW  = 424;
    localparam int NV  = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_entry_we = 1'b0;
    logic [5:0]    cfg_entry_idx = '0;
    logic [KW-1:0] cfg_entry_val = '0;
    logic [KW-1:0] cfg_entry_msk = '0;
    logic [15:0]   cfg_entry_flags = '0;
    logic [15:0]   cfg_entry_result = '0;
    logic          cfg_mode_we = 1'b0;
    logic [31:0]   cfg_mode_data = '0;
    logic          cfg_win_we = 1'b0;
    logic [27:0]   cfg_win_data = '0;
    logic          cfg_err;
    logic [3:0]    cap_code;
    logic          lk_valid = 1'b0;
    logic [1:0]    lk_si = '0;
    logic [KW-1:0] lk_key = '0;
    logic          res_valid, res_match;
    logic [5:0]    res_index;
    logic [15:0]   res_result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tfs_match_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_entry_we(cfg_entry_we), .cfg_entry_idx(cfg_entry_idx),
        .cfg_entry_val(cfg_entry_val), .cfg_entry_msk(cfg_entry_msk),
        .cfg_entry_flags(cfg_entry_flags), .cfg_entry_result(cfg_entry_result),
        .cfg_mode_we(cfg_mode_we), .cfg_mode_data(cfg_mode_data),
        .cfg_win_we(cfg_win_we), .cfg_win_data(cfg_win_data),
        .cfg_err(cfg_err), .cap_code(cap_code),
        .lk_valid(lk_valid), .lk_si(lk_si), .lk_key(lk_key),
        .res_valid(res_valid), .res_match(res_match),
        .res_index(res_index), .res_result(res_result)
    );

    // vector: {si[2], byte[8], flip_en, flip_idx[9], match, idx[6], result[16]}
    localparam logic [42:0] VEC [NV] = '{
        {2'd0, 8'h11, 1'b0, 9'd0,   1'b1, 6'd0,  16'h1000}, // R3 three hits, lowest wins
        {2'd0, 8'h11, 1'b1, 9'd20,  1'b1, 6'd1,  16'h1001}, // R1 protocol-only mask
        {2'd0, 8'h22, 1'b0, 9'd0,   1'b1, 6'd2,  16'h1002}, // R1 full wildcard
        {2'd1, 8'h22, 1'b0, 9'd0,   1'b1, 6'd4,  16'h2004}, // R4 first entry of window
        {2'd1, 8'h33, 1'b0, 9'd0,   1'b1, 6'd5,  16'h2005}, // R4
        {2'd1, 8'h44, 1'b0, 9'd0,   1'b1, 6'd11, 16'h200B}, // R4 last entry of window
        {2'd1, 8'h55, 1'b0, 9'd0,   1'b0, 6'd0,  16'h0000}, // R9 R4 match only outside
        {2'd3, 8'h55, 1'b0, 9'd0,   1'b1, 6'd12, 16'h300C}, // R4 window after empty one
        {2'd3, 8'h55, 1'b1, 9'd423, 1'b1, 6'd12, 16'h300C}, // R1 masked source MAC
        {2'd3, 8'h55, 1'b1, 9'd0,   1'b0, 6'd0,  16'h0000}, // R1 compared bit differs
        {2'd2, 8'h11, 1'b0, 9'd0,   1'b0, 6'd0,  16'h0000}, // R4 empty window
        {2'd3, 8'h66, 1'b0, 9'd0,   1'b0, 6'd0,  16'h0000}, // R4 entry past all windows
        {2'd0, 8'h66, 1'b0, 9'd0,   1'b1, 6'd2,  16'h1002}  // R3 wildcard below
    };

    function automatic logic [KW-1:0] mk(input logic [7:0] b);
        mk = {53{b}};
    endfunction

    function automatic logic [27:0] wins(input int s0, input int s1, input int s2, input int s3);
        wins = {7'(s3), 7'(s2), 7'(s1), 7'(s0)};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr_entry(input int idx, input logic [KW-1:0] v, input logic [KW-1:0] m,
                            input logic [15:0] fl, input logic [15:0] r);
        @(negedge clk);
        cfg_entry_we = 1'b1; cfg_entry_idx = 6'(idx);
        cfg_entry_val = v; cfg_entry_msk = m; cfg_entry_flags = fl; cfg_entry_result = r;
        @(negedge clk);
        cfg_entry_we = 1'b0;
    endtask

    task automatic wr_mode(input logic [31:0] d);
        @(negedge clk);
        cfg_mode_we = 1'b1; cfg_mode_data = d;
        @(negedge clk);
        cfg_mode_we = 1'b0;
    endtask

    task automatic wr_win(input logic [27:0] d);
        @(negedge clk);
        cfg_win_we = 1'b1; cfg_win_data = d;
        @(negedge clk);
        cfg_win_we = 1'b0;
    endtask

    // drives one lookup, samples one cycle later, checks
    task automatic look(input string req, input int si, input logic [KW-1:0] k,
                        input logic m, input int idx, input logic [15:0] r);
        @(negedge clk);
        lk_valid = 1'b1; lk_si = 2'(si); lk_key = k;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, 32'({res_valid, res_match, res_index, res_result}),
                 32'({1'b1, m, 6'(idx), r}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 res_valid after reset", 32'(res_valid), 32'd0);
        chk("R10 cfg_err after reset", 32'(cfg_err), 32'd0);
        chk("R6 cap_code", 32'(cap_code), 32'd3);

        wr_win(wins(4, 8, 0, 4));
        chk("R5 legal window", 32'(cfg_err), 32'd0);

        wr_entry(0,  mk(8'h11), '1,                        16'h8000, 16'h1000);
        wr_entry(1,  mk(8'h11), KW'(8'hFF),                16'h8000, 16'h1001);
        wr_entry(2,  mk(8'h00), '0,                        16'h8000, 16'h1002);
        wr_entry(3,  mk(8'h22), '1,                        16'h7FFF, 16'h1003);
        wr_entry(4,  mk(8'h22), '1,                        16'h8000, 16'h2004);
        wr_entry(5,  mk(8'h33), '1,                        16'h8000, 16'h2005);
        wr_entry(11, mk(8'h44), '1,                        16'h8000, 16'h200B);
        wr_entry(12, mk(8'h55), {48'd0, {376{1'b1}}},      16'h8000, 16'h300C);
        wr_entry(16, mk(8'h66), '1,                        16'h8000, 16'h4010);

        look("R7 table off", 0, mk(8'h11), 1'b0, 0, 16'h0);
        wr_mode(32'h7FFF_FFFF);
        look("R7 bit31 clear", 0, mk(8'h11), 1'b0, 0, 16'h0);
        wr_mode(32'h8000_0000);

        for (int v = 0; v < NV; v++) begin
            logic [KW-1:0] k;
            k = mk(VEC[v][40:33]);
            if (VEC[v][32]) k[VEC[v][31:23]] = ~k[VEC[v][31:23]];
            look($sformatf("R1/R3/R4/R9 vector %0d", v), int'(VEC[v][42:41]), k,
                 VEC[v][22], int'(VEC[v][21:16]), VEC[v][15:0]);
        end

        @(negedge clk);
        chk("R8 idle cycle", 32'(res_valid), 32'd0);

        wr_entry(2, mk(8'h00), '0, 16'h7FFF, 16'h1002);
        look("R2 disabled entries", 0, mk(8'h22), 1'b0, 0, 16'h0);
        wr_entry(3, mk(8'h22), '1, 16'h8000, 16'h1003);
        look("R2 enabled entry", 0, mk(8'h22), 1'b1, 3, 16'h1003);

        wr_win(wins(64, 0, 0, 0));
        chk("R5 total equals capacity", 32'(cfg_err), 32'd0);
        look("R5 full window", 0, mk(8'h66), 1'b1, 16, 16'h4010);
        wr_win(wins(10, 55, 0, 0));
        chk("R5 over capacity flag", 32'(cfg_err), 32'd1);
        look("R5 old windows kept", 0, mk(8'h66), 1'b1, 16, 16'h4010);
        wr_win(wins(4, 8, 0, 4));
        chk("R5 flag cleared", 32'(cfg_err), 32'd0);
        look("R4 windows restored", 1, mk(8'h44), 1'b1, 11, 16'h200B);

        wr_mode(32'h0000_0000);
        look("R7 disabled again", 1, mk(8'h44), 1'b0, 0, 16'h0);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wr_mode(32'h8000_0000);
        wr_win(wins(4, 8, 0, 4));
        look("R10 entries cleared", 0, mk(8'h11), 1'b0, 0, 16'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule